// File: doc/BRIEF.md
# Buffered-duty PWM timer

This block produces one pulse-width-modulated output from an 8-bit duty value. An up-counter steps once per tick of a divided clock and runs through 250 states, 0x00 to 0xF9, before it returns to 0x00. The output is at its active level for counter states 1 up to the duty value. Duty values at or above 0xFA hold the output active for the whole period. A duty of 0x00 holds it inactive.

Software programs the block through a narrow write port that has two registers. The duty register is double-buffered. While the timer runs, a new duty value waits in a holding register and is loaded into the compare register only when the counter wraps, so a period never mixes two duty values. While the timer is stopped, a written duty value reaches the compare register at once. The control register holds the run bit, the polarity bit and the 3-bit tick-rate code. An ownership flag tells the surrounding port logic whether the pin is driven by this timer or left to general-purpose I/O.

Top module: `duty_pwm_timer`

## Requirements
- R1: While the run bit is 0, the counter stays at 0x00, `pwm_out` is 0 and `pwm_own` is 0. Duty writes made in this state do not disturb the output. While the run bit is 1, `pwm_own` is 1.
- R2: A duty value written while stopped is already in force in the first period after the timer starts.
- R3: While running, the counter advances once per tick from 0x00 to 0xF9 and then returns to 0x00. A period is therefore 250 ticks, and consecutive output rising edges are 250 ticks apart.
- R4: A duty value written while running takes effect only from the counter wrap (0xF9 to 0x00) that follows the write. The period in progress keeps the old duty.
- R5: For a duty value d from 0x01 to 0xF9, the output is active during counter states 1 through d, which is d ticks per period. It becomes active exactly once per period.
- R6: A duty value of 0x00 keeps the output inactive for the whole period.
- R7: Duty values from 0xFA to 0xFF keep the output active for the whole period, including counter state 0x00.
- R8: With polarity 0, active is high. With polarity 1, the output is inverted, so active is low and inactive is high.
- R9: A tick-rate code k (0 to 7) gives one counter tick every 2^(k+1) clocks, taken from a prescaler that runs freely.
- R10: The polarity and tick-rate fields are taken only by a control write made while the run bit is 0. This includes the write that sets the run bit. While the timer is running, writes to these two fields are ignored.
- R11: `pwm_out` is a register. It changes one clock after the counter or control state that causes the change. Reset clears every register: stopped, duty 0x00, polarity 0, code 0.

Register map (`wr_sel`): 0 selects the duty register, using all 8 bits of `wr_data`. 1 selects the control register, with bit 0 the run bit, bit 1 the polarity bit and bits 4:2 the tick-rate code. A write happens on a rising clock edge when `wr_en` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 duty, 1 control |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | Registered PWM pin value |
| pwm_own | output | 1 | 1 when the timer owns the pin, 0 when the pin is left to general-purpose I/O |

## Verification
A counter stuck or wrapping at the wrong state changes the spacing of the rising edges and the number of active clocks in a period. Both show within one period, which is 250 ticks. A compare register loaded at the wrong time shows as a period whose active length belongs to neither the old duty nor the new one. This appears in the period during which the write lands. A wrong output decode shows within one clock at the stop and start edges. A wrong saturation or zero decode shows as a stray edge somewhere in a single period.

// File: rtl/duty_pwm_pkg.sv
package duty_pwm_pkg;

   // Width of the tick-rate field in the control register
   localparam int unsigned RATE_W = 3;
   // Number of selectable divide ratios
   localparam int unsigned RATE_N = 2 ** RATE_W;
   // Prescaler width needed for the largest ratio 2^RATE_N
   localparam int unsigned PRE_W  = RATE_N;

   // Register select values
   typedef enum logic {
      SEL_DUTY = 1'b0,
      SEL_CTRL = 1'b1
   } reg_sel_e;

   // Control register layout, LSB last: rate[4:2], pol[1], run[0]
   typedef struct packed {
      logic [RATE_W-1:0] rate;
      logic              pol;
      logic              run;
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/duty_pwm_prescaler.sv
module duty_pwm_prescaler
   import duty_pwm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate,
   output logic              tick
);

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask_tab [RATE_N];
   logic [PRE_W-1:0] mask_sel;

   // One low-bit mask per divide ratio: code k needs k+1 ones
   for (genvar gi = 0; gi < RATE_N; gi++) begin : g_mask
      localparam logic [PRE_W-1:0] MASK_K = PRE_W'((64'd1 << (gi + 1)) - 64'd1);
      assign mask_tab[gi] = MASK_K;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;
   end

   assign mask_sel = mask_tab[rate];
   assign tick     = (pre_q & mask_sel) == mask_sel;

   // R9
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick)
      else $error("tick on two adjacent clocks");

endmodule

// File: rtl/duty_pwm_counter.sv
module duty_pwm_counter #(
   parameter int CNT_W  = 8,
   parameter int PERIOD = 250
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

   logic [CNT_W-1:0] cnt_q;

   assign wrap = run && tick && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || !run)  cnt_q <= '0;
      else if (wrap)       cnt_q <= '0;
      else if (tick)       cnt_q <= cnt_q + 1'b1;
   end

   assign cnt = cnt_q;

   // R1
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0))
      else $error("counter moved while stopped");

   // R3
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST)
      else $error("counter beyond last state");

   // R3
   cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt_q == '0))
      else $error("counter did not wrap");

endmodule

// File: rtl/duty_pwm_shaper.sv
module duty_pwm_shaper #(
   parameter int CNT_W  = 8,
   parameter int PERIOD = 250
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             pol,
   input  logic             wrap,
   input  logic [CNT_W-1:0] cnt,
   input  logic             duty_we,
   input  logic [CNT_W-1:0] duty_wd,
   output logic             pwm
);

   localparam logic [CNT_W-1:0] SAT = CNT_W'(PERIOD);

   logic [CNT_W-1:0] hold_q;
   logic [CNT_W-1:0] cmp_q;
   logic             pwm_q;
   logic             active;

   // Holding register always takes writes; the compare register is fed
   // straight through while stopped and at the wrap while running.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
         cmp_q  <= '0;
      end else begin
         if (duty_we) hold_q <= duty_wd;
         if (!run)    cmp_q  <= duty_we ? duty_wd : hold_q;
         else if (wrap) cmp_q <= hold_q;
      end
   end

   always_comb begin
      if (cmp_q >= SAT)        active = 1'b1;
      else if (cmp_q == '0)    active = 1'b0;
      else                     active = (cnt != '0) && (cnt <= cmp_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   pwm_q <= 1'b0;
      else if (run) pwm_q <= active ^ pol;
      else          pwm_q <= 1'b0;
   end

   assign pwm = pwm_q;

   // R4
   shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run) && (cmp_q != $past(cmp_q))) |-> $past(wrap))
      else $error("compare register loaded away from wrap");

   // R1
   stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !pwm_q)
      else $error("output driven while stopped");

   // R6
   zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cmp_q == '0) |=> (pwm_q == $past(pol)))
      else $error("zero duty produced active level");

   // R7
   full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cmp_q >= SAT) |=> (pwm_q == !$past(pol)))
      else $error("saturated duty produced inactive level");

endmodule

// File: rtl/duty_pwm_timer.sv
module duty_pwm_timer
   import duty_pwm_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int PERIOD = 250
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   output logic             pwm_out,
   output logic             pwm_own
);

   // Elaboration-time parameter checks
   if (PERIOD < 2 || PERIOD >= (2 ** CNT_W)) begin : g_bad_period
      $error("PERIOD must lie in 2 .. 2**CNT_W-1 so saturation is reachable");
   end
   if (CNT_W < int'(CTRL_W)) begin : g_bad_width
      $error("CNT_W too narrow to carry the control fields");
   end

   ctrl_t            ctrl_q;
   ctrl_t            ctrl_wd;
   logic             ctrl_we;
   logic             duty_we;
   logic             tick;
   logic             wrap;
   logic [CNT_W-1:0] cnt;

   assign ctrl_wd = ctrl_t'(wr_data[CTRL_W-1:0]);
   assign ctrl_we = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
   assign duty_we = wr_en && (reg_sel_e'(wr_sel) == SEL_DUTY);

   // Rate and polarity are taken only while stopped; run always updates.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_we) begin
         ctrl_q.run <= ctrl_wd.run;
         if (!ctrl_q.run) begin
            ctrl_q.pol  <= ctrl_wd.pol;
            ctrl_q.rate <= ctrl_wd.rate;
         end
      end
   end

   duty_pwm_prescaler u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .rate  (ctrl_q.rate),
      .tick  (tick)
   );

   duty_pwm_counter #(.CNT_W(CNT_W), .PERIOD(PERIOD)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ctrl_q.run),
      .tick  (tick),
      .cnt   (cnt),
      .wrap  (wrap)
   );

   duty_pwm_shaper #(.CNT_W(CNT_W), .PERIOD(PERIOD)) u_shp (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl_q.run),
      .pol     (ctrl_q.pol),
      .wrap    (wrap),
      .cnt     (cnt),
      .duty_we (duty_we),
      .duty_wd (wr_data),
      .pwm     (pwm_out)
   );

   assign pwm_own = ctrl_q.run;

   // R10
   cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctrl_q.run) |-> $stable(ctrl_q.rate) && $stable(ctrl_q.pol))
      else $error("rate or polarity changed while running");

endmodule

// File: tb/duty_pwm_timer_bench.sv
`timescale 1ns/1ps
module duty_pwm_timer_bench;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       wr_en;
   logic       wr_sel;
   logic [7:0] wr_data;
   logic       pwm_out;
   logic       pwm_own;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   duty_pwm_timer u_duty_pwm_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .pwm_out (pwm_out),
      .pwm_own (pwm_own)
   );

   // Columns: duty, polarity, rate code, expected active-high clocks in
   // one period, expected rising edges in one period.
   localparam int NV = 9;
   localparam int VEC [NV][5] = '{
      '{8'h00, 0, 0,    0, 0},   // R6
      '{8'h01, 0, 0,    2, 1},   // R5
      '{8'h80, 0, 1,  512, 1},   // R5 R9
      '{8'hF9, 0, 0,  498, 1},   // R5
      '{8'hFA, 0, 0,  500, 0},   // R7
      '{8'hFF, 0, 2, 2000, 0},   // R7 R9
      '{8'h40, 1, 0,  372, 1},   // R8
      '{8'h00, 1, 1, 1000, 0},   // R6 R8
      '{8'h7D, 1, 2, 1000, 1}    // R8 R9
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   task automatic wr(input bit sel, input int data);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_sel  = sel;
      wr_data = 8'(data);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   function automatic int ctrl(input int rate, input int pol, input int run);
      return (rate << 2) | (pol << 1) | run;
   endfunction

   task automatic measure(input int n, output int highs, output int rises);
      logic prev;
      highs = 0;
      rises = 0;
      prev  = pwm_out;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (pwm_out) highs++;
         if (pwm_out && !prev) rises++;
         prev = pwm_out;
      end
   endtask

   task automatic wait_rise();
      logic prev;
      prev = pwm_out;
      for (int k = 0; k < 100000; k++) begin
         @(negedge clk);
         if (pwm_out && !prev) break;
         prev = pwm_out;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
   end

   initial begin
      int hi;
      int rs;
      int per;
      int gap;
      logic prev;
      rst_n   = 1'b0;
      wr_en   = 1'b0;
      wr_sel  = 1'b0;
      wr_data = 8'h00;
      repeat (4) @(negedge clk);
      check("R11 reset pwm_out", int'(pwm_out), 0);
      check("R1 reset pwm_own", int'(pwm_own), 0);
      rst_n = 1'b1;

      // R1: stopped, a saturating duty must not reach the pin
      wr(0, 8'hFF);
      repeat (20) @(negedge clk);
      check("R1 stopped pwm_out", int'(pwm_out), 0);
      check("R1 stopped pwm_own", int'(pwm_own), 0);

      // Vector table
      for (int i = 0; i < NV; i++) begin
         wr(1, ctrl(0, 0, 0));
         wr(0, VEC[i][0]);
         wr(1, ctrl(VEC[i][2], VEC[i][1], 1));
         check($sformatf("R1 vec%0d pwm_own", i), int'(pwm_own), 1);
         per = 250 * (2 << VEC[i][2]);
         repeat (per + 10) @(negedge clk);
         measure(per, hi, rs);
         check($sformatf("R5 R9 vec%0d active clocks", i), hi, VEC[i][3]);
         check($sformatf("R5 vec%0d rising edges", i), rs, VEC[i][4]);
      end

      // R11 and R7: start and stop edges with saturated duty
      wr(1, ctrl(0, 0, 0));
      wr(0, 8'hFA);
      wr(1, ctrl(0, 0, 1));
      check("R11 output lags start", int'(pwm_out), 0);
      @(negedge clk);
      check("R7 active at count 0", int'(pwm_out), 1);
      repeat (50) @(negedge clk);
      wr(1, ctrl(0, 0, 0));
      check("R11 output lags stop", int'(pwm_out), 1);
      @(negedge clk);
      check("R1 inactive after stop", int'(pwm_out), 0);
      check("R1 pwm_own after stop", int'(pwm_own), 0);

      // R2: duty written while stopped holds from the first period
      wr(0, 8'h10);
      wr(1, ctrl(0, 0, 1));
      repeat (600) @(negedge clk);
      wr(1, ctrl(0, 0, 0));
      wr(0, 8'h30);
      wr(1, ctrl(0, 0, 1));
      measure(500, hi, rs);
      check("R2 first period duty", hi, 96);

      // R4: write while running, period in progress keeps old duty
      wait_rise();
      wr(0, 8'hC0);
      measure(500, hi, rs);
      check("R4 old duty kept", hi, 96);
      measure(500, hi, rs);
      check("R4 new duty after wrap", hi, 384);

      // R3: rising edges are 250 ticks apart (rate 0: 500 clocks)
      wait_rise();
      gap  = 0;
      prev = 1'b1;
      for (int k = 0; k < 5000; k++) begin
         @(negedge clk);
         gap++;
         if (pwm_out && !prev) break;
         prev = pwm_out;
      end
      check("R3 rise spacing", gap, 500);

      // R10: rate and polarity writes ignored while running
      wr(1, ctrl(3, 1, 1));
      repeat (600) @(negedge clk);
      measure(500, hi, rs);
      check("R10 active clocks unchanged", hi, 384);
      check("R10 rising edges unchanged", rs, 1);

      summary();
   end

endmodule